// File: doc/BRIEF.md
# Delegated Interrupt Enable and Pending Registers

This block keeps the machine-level interrupt enable word, the software-visible part of the interrupt pending word and the interrupt delegation mask of a processor hart. It accepts single-cycle register writes from the instruction pipeline, applies the legalization rules of each register, and drives a combinational read value for the addressed register. It also exports the full enable, pending and delegation words to the interrupt selection logic that sits next to it.

Two supervisor-level windows are provided on the same storage. Reading either window returns only the supervisor interrupt bits that are delegated. Writing the enable window touches only delegated bits. Writing the pending window may change only the supervisor software interrupt, and only when that bit is delegated. Hardware pending sources for the external, timer and software interrupts are merged into the pending value as it is read, and software cannot clear them.

Top module: `intr_deleg_csr`

## Requirements
- R1: Interrupt bits sit at fixed positions: supervisor software 1, machine software 3, supervisor timer 5, machine timer 7, supervisor external 9, machine external 11. Every other bit of the enable, pending and delegation words and of the supervisor windows reads 0. After reset all three registers read 0.
- R2: A write to the delegation register (0x303) stores bits 1, 5 and 9 from the write data and always leaves bits 3, 7 and 11 at 0.
- R3: A write to the enable register (0x304) always stores bits 3, 7 and 11. Bits 1, 5 and 9 are stored only when `sup_present` is 1 and are written as 0 otherwise.
- R4: A write to the pending register (0x344) changes only bits 1, 5 and 9, and only when `sup_present` is 1; with `sup_present` 0 these bits are written as 0. Bits 3, 7 and 11 cannot be set by software.
- R5: On a pending register write, bit 5 keeps its old value when `tcmp_present` and `tcmp_en` are both 1.
- R6: Reading the supervisor enable window (0x104) or supervisor pending window (0x144) returns bits 1, 5 and 9 of the enable or pending value ANDed with the matching delegation bits.
- R7: A write to the supervisor enable window changes each of bits 1, 5 and 9 of the enable register only when the matching delegation bit is 1.
- R8: A write to the supervisor pending window changes only pending bit 1, and only when delegation bit 1 is 1.
- R9: The hardware inputs `hw_mei`, `hw_mti`, `hw_msi` and `hw_sei` are ORed into pending bits 11, 7, 3 and 9 in the same cycle, and no software write clears them.
- R10: Writes to either supervisor window have no effect while `sup_present` is 0.
- R11: Addresses other than the five above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe for one cycle |
| csr_addr | input | 12 | Register address for read and write |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for `csr_addr`, combinational |
| sup_present | input | 1 | Supervisor mode implemented |
| tcmp_present | input | 1 | Timer-compare feature implemented |
| tcmp_en | input | 1 | Timer-compare feature enabled |
| hw_mei | input | 1 | Hardware machine external interrupt |
| hw_mti | input | 1 | Hardware machine timer interrupt |
| hw_msi | input | 1 | Hardware machine software interrupt |
| hw_sei | input | 1 | Hardware supervisor external interrupt |
| irq_enable | output | XLEN | Current enable word |
| irq_pending | output | XLEN | Current pending word including hardware sources |
| irq_deleg | output | XLEN | Current delegation word |

## Verification
The assertions check on every cycle that the machine bits of the delegation word stay clear, that no word carries a bit outside the six interrupt positions, that hardware sources appear in the pending word, and that both supervisor windows read as the masked values. They also check, cycle by cycle, that the timer pending bit holds under timer compare, that an undelegated enable bit survives a supervisor-window write and that enable writes without supervisor mode clear the supervisor bits. Only the bench scenarios show the stored values after particular write sequences: partial delegation patterns, supervisor-window writes with supervisor mode absent, the release of hardware sources and writes to unmapped addresses.

// File: rtl/intr_deleg_csr.sv
module intr_deleg_csr #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            sup_present,
  input  logic            tcmp_present,
  input  logic            tcmp_en,
  input  logic            hw_mei,
  input  logic            hw_mti,
  input  logic            hw_msi,
  input  logic            hw_sei,
  output logic [XLEN-1:0] irq_enable,
  output logic [XLEN-1:0] irq_pending,
  output logic [XLEN-1:0] irq_deleg
);
  localparam logic [11:0] A_EN   = 12'h304;
  localparam logic [11:0] A_PEND = 12'h344;
  localparam logic [11:0] A_DLG  = 12'h303;
  localparam logic [11:0] A_SEN  = 12'h104;
  localparam logic [11:0] A_SPND = 12'h144;
  localparam int SSI = 1, MSI = 3, STI = 5, MTI = 7, SEI = 9, MEI = 11;

  logic en_ssi, en_msi, en_sti, en_mti, en_sei, en_mei;
  logic sp_ssi, sp_sti, sp_sei;
  logic dl_ssi, dl_sti, dl_sei;
  logic sti_locked;

  assign sti_locked = tcmp_present & tcmp_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en_ssi, en_msi, en_sti, en_mti, en_sei, en_mei} <= '0;
      {sp_ssi, sp_sti, sp_sei} <= '0;
      {dl_ssi, dl_sti, dl_sei} <= '0;
    end else if (csr_we) begin
      case (csr_addr)
        A_EN: begin
          en_msi <= csr_wdata[MSI];
          en_mti <= csr_wdata[MTI];
          en_mei <= csr_wdata[MEI];
          en_ssi <= sup_present & csr_wdata[SSI];
          en_sti <= sup_present & csr_wdata[STI];
          en_sei <= sup_present & csr_wdata[SEI];
        end
        A_PEND: begin
          sp_ssi <= sup_present & csr_wdata[SSI];
          sp_sei <= sup_present & csr_wdata[SEI];
          if (!sup_present)     sp_sti <= 1'b0;
          else if (!sti_locked) sp_sti <= csr_wdata[STI];
        end
        A_DLG: begin
          dl_ssi <= csr_wdata[SSI];
          dl_sti <= csr_wdata[STI];
          dl_sei <= csr_wdata[SEI];
        end
        A_SEN: if (sup_present) begin
          if (dl_ssi) en_ssi <= csr_wdata[SSI];
          if (dl_sti) en_sti <= csr_wdata[STI];
          if (dl_sei) en_sei <= csr_wdata[SEI];
        end
        A_SPND: if (sup_present && dl_ssi) sp_ssi <= csr_wdata[SSI];
        default: ;
      endcase
    end
  end

  always_comb begin
    irq_enable = '0;
    irq_enable[SSI] = en_ssi;
    irq_enable[MSI] = en_msi;
    irq_enable[STI] = en_sti;
    irq_enable[MTI] = en_mti;
    irq_enable[SEI] = en_sei;
    irq_enable[MEI] = en_mei;

    irq_pending = '0;
    irq_pending[SSI] = sp_ssi;
    irq_pending[MSI] = hw_msi;
    irq_pending[STI] = sp_sti;
    irq_pending[MTI] = hw_mti;
    irq_pending[SEI] = sp_sei | hw_sei;
    irq_pending[MEI] = hw_mei;

    irq_deleg = '0;
    irq_deleg[SSI] = dl_ssi;
    irq_deleg[STI] = dl_sti;
    irq_deleg[SEI] = dl_sei;
  end

  always_comb begin
    case (csr_addr)
      A_EN:    csr_rdata = irq_enable;
      A_PEND:  csr_rdata = irq_pending;
      A_DLG:   csr_rdata = irq_deleg;
      A_SEN:   csr_rdata = irq_enable & irq_deleg;
      A_SPND:  csr_rdata = irq_pending & irq_deleg;
      default: csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intr_deleg_csr_chk.sv
module intr_deleg_csr_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_we,
  input logic [11:0]     csr_addr,
  input logic [XLEN-1:0] csr_rdata,
  input logic            sup_present,
  input logic            tcmp_present,
  input logic            tcmp_en,
  input logic            hw_mei,
  input logic            hw_mti,
  input logic            hw_msi,
  input logic            hw_sei,
  input logic [XLEN-1:0] irq_enable,
  input logic [XLEN-1:0] irq_pending,
  input logic [XLEN-1:0] irq_deleg
);
  localparam logic [XLEN-1:0] ALL_BITS = XLEN'(12'hAAA);
  localparam logic [XLEN-1:0] M_BITS   = XLEN'(12'h888);
  localparam logic [XLEN-1:0] S_BITS   = XLEN'(12'h222);

  p_deleg_mbits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_deleg & M_BITS) == '0);

  p_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_enable | irq_pending | irq_deleg) & ~ALL_BITS) == '0);

  p_hw_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mei -> irq_pending[11]) && (hw_mti -> irq_pending[7]) &&
    (hw_msi -> irq_pending[3]) && (hw_sei -> irq_pending[9]));

  p_sview_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'h104) |-> csr_rdata == (irq_enable & irq_deleg & S_BITS));

  p_spview_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'h144) |-> csr_rdata == (irq_pending & irq_deleg & S_BITS));

  p_sti_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'h344 && tcmp_present && tcmp_en && sup_present)
      |=> $stable(irq_pending[5]));

  p_en_nosup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'h304 && !sup_present) |=> (irq_enable & S_BITS) == '0);

  p_sie_undeleg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'h104 && !irq_deleg[9]) |=> $stable(irq_enable[9]));
endmodule

bind intr_deleg_csr intr_deleg_csr_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
  .csr_rdata(csr_rdata), .sup_present(sup_present),
  .tcmp_present(tcmp_present), .tcmp_en(tcmp_en),
  .hw_mei(hw_mei), .hw_mti(hw_mti), .hw_msi(hw_msi), .hw_sei(hw_sei),
  .irq_enable(irq_enable), .irq_pending(irq_pending), .irq_deleg(irq_deleg)
);

// File: tb/intr_deleg_csr_tb.sv
module intr_deleg_csr_tb;
  localparam int XLEN = 32;
  logic clk = 0, rst_n = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata, irq_enable, irq_pending, irq_deleg;
  logic sup_present = 1, tcmp_present = 0, tcmp_en = 0;
  logic hw_mei = 0, hw_mti = 0, hw_msi = 0, hw_sei = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_deleg_csr #(.XLEN(XLEN)) u_dut (.*);

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 0; csr_wdata = '0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [XLEN-1:0] exp, input string req);
    @(negedge clk);
    csr_addr = a;
    #1;
    checks++;
    if (csr_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, csr_rdata, exp);
    end
  endtask

  task automatic t_reset;
    rd_chk(12'h304, 0, "R1"); rd_chk(12'h344, 0, "R1"); rd_chk(12'h303, 0, "R1");
    rd_chk(12'h104, 0, "R1"); rd_chk(12'h144, 0, "R1");
  endtask

  task automatic t_enable;
    sup_present = 1; wr(12'h304, '1); rd_chk(12'h304, 32'hAAA, "R3");
    sup_present = 0; wr(12'h304, '1); rd_chk(12'h304, 32'h888, "R3");
    sup_present = 1;
  endtask

  task automatic t_deleg;
    wr(12'h303, '1); rd_chk(12'h303, 32'h222, "R2");
  endtask

  task automatic t_pending;
    wr(12'h344, '1); rd_chk(12'h344, 32'h222, "R4");
    wr(12'h344, 0);  rd_chk(12'h344, 0, "R4");
    sup_present = 0; wr(12'h344, '1); rd_chk(12'h344, 0, "R4");
    sup_present = 1;
  endtask

  task automatic t_sti_lock;
    wr(12'h344, 32'h20); rd_chk(12'h344, 32'h20, "R5");
    tcmp_present = 1; tcmp_en = 1; wr(12'h344, 0); rd_chk(12'h344, 32'h20, "R5");
    tcmp_en = 0; wr(12'h344, 0); rd_chk(12'h344, 0, "R5");
    tcmp_present = 0;
  endtask

  task automatic t_sview;
    wr(12'h304, '1); wr(12'h303, 32'h200); wr(12'h344, 32'h222);
    rd_chk(12'h104, 32'h200, "R6"); rd_chk(12'h144, 32'h200, "R6");
  endtask

  task automatic t_sie_write;
    wr(12'h303, 32'h020); wr(12'h104, 0); rd_chk(12'h304, 32'hA8A, "R7");
  endtask

  task automatic t_sip_write;
    wr(12'h303, 32'h002); wr(12'h144, 0); rd_chk(12'h344, 32'h220, "R8");
    wr(12'h303, 0); wr(12'h144, 32'h2); rd_chk(12'h344, 32'h220, "R8");
  endtask

  task automatic t_hw;
    hw_mei = 1; hw_mti = 1; rd_chk(12'h344, 32'hAA0, "R9");
    wr(12'h344, 0); rd_chk(12'h344, 32'h880, "R9");
    hw_msi = 1; hw_sei = 1; rd_chk(12'h344, 32'hA88, "R9");
    hw_mei = 0; hw_mti = 0; hw_msi = 0; hw_sei = 0; rd_chk(12'h344, 0, "R9");
  endtask

  task automatic t_nosup_sview;
    wr(12'h304, '1); wr(12'h303, 32'h222);
    sup_present = 0; wr(12'h104, 0); wr(12'h144, 32'h2);
    rd_chk(12'h304, 32'hAAA, "R10"); rd_chk(12'h344, 0, "R10");
    sup_present = 1;
  endtask

  task automatic t_unmapped;
    rd_chk(12'h305, 0, "R11");
    wr(12'h305, 0); rd_chk(12'h304, 32'hAAA, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_enable(); t_deleg(); t_pending(); t_sti_lock();
    t_sview(); t_sie_write(); t_sip_write(); t_hw(); t_nosup_sview(); t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule